// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag, valid and dirty bookkeeping of a set-associative first-level cache. It decides where each access lands and reports that as a class: hit, fill of an empty way, clean eviction, or dirty eviction. Data arrays, refill traffic and writeback paths are outside the block. A requester uses its outcome and way number to steer those paths.

Requests arrive on a valid/ready channel. `req_ready` is low while reset is asserted and high on every cycle after it. A request is taken on any rising edge where both `req_valid` and `req_ready` are high. Every operation, including the whole-cache ones, completes in the cycle it is taken, so the block never applies back-pressure outside reset. The outcome port is a plain registered status, with no handshake.

Beyond lookups, the block accepts several maintenance commands:
- a whole-cache dirty clear;
- a whole-cache valid clear;
- a test-restart, which also zeroes the replacement trees;
- per-address clean and per-address drop commands, which touch only the matching line.

Replacement uses a binary tree of pseudo-LRU bits for each set.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The address splits into three fields. The tag is the top TAG_W bits. The set index is the log2(SETS) bits directly below the tag. The remaining low bits are the offset, and the offset never affects the result.
- R2: A lookup (op 0) hits when a valid way of the indexed set holds the request tag. The outcome is code 1 and `res_way` gives that way. A hit with `req_write`=1 marks the line dirty.
- R3: A lookup that misses while the set has an invalid way fills the lowest-numbered invalid way. The fill stores the tag, sets valid, and copies `req_write` into dirty. The outcome is code 2 with that way.
- R4: A lookup that misses in a full set overwrites the victim way chosen by the replacement tree. The outcome is code 4 if the victim was dirty and code 3 otherwise. The new line takes dirty=`req_write`.
- R5: Each set has WAYS-1 tree bits in heap order: node 0 is the root, and node i has children 2i+1 and 2i+2. Leaf node k covers ways 2k-(WAYS-2) and the way after it. To pick a victim, start at the root: bit 0 goes to the left (lower) child and bit 1 goes to the right child. At a leaf, bit 1 picks the odd way. Every hit, fill or eviction sets the bits on the path of the used way so that they point away from it. The leaf bit is 1 when an even way is used.
- R6: Flush-all (op 1) clears every dirty bit and keeps tags and valid bits.
- R7: Invalidate-all (op 2) clears every valid bit. Restart (op 5) does the same and also zeroes every tree bit.
- R8: Clean-line (op 3) clears the dirty bit of the valid line that matches the address. Drop-line (op 4) clears that line's valid and dirty bits. Neither command changes tree bits.
- R9: The outcome is registered. A lookup taken at edge k shows on `res_code`/`res_way` after edge k. After any edge that took no lookup, `res_code` is 0 (none). Ops 6 and 7 have no effect.
- R10: `req_ready` is 0 while `rst_n` is low and 1 on every cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 3 | Operation code (0 lookup, 1 flush-all, 2 invalidate-all, 3 clean-line, 4 drop-line, 5 restart) |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | Lookup is a store-class access |
| res_code | output | 3 | Outcome: 0 none, 1 hit, 2 fill, 3 clean eviction, 4 dirty eviction |
| res_way | output | log2(WAYS) | Way used by the last lookup |

## Verification
Each lookup's outcome and way become visible one register stage after the edge that takes the request. The bench drives the request at a falling edge and reads the result 1 ns after the next rising edge. The same sample shows the none code that must follow each maintenance command. Maintenance commands change no output directly. Their effect on dirty, valid and tree state is checked at the next lookups, and those results are due in the same single-cycle window. Reset values are read while reset is held and again on the first cycle after release.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  typedef enum logic [2:0] {
    OP_LOOKUP     = 3'd0,
    OP_FLUSH_ALL  = 3'd1,
    OP_DROP_ALL   = 3'd2,
    OP_CLEAN_LINE = 3'd3,
    OP_DROP_LINE  = 3'd4,
    OP_RESTART    = 3'd5
  } ctc_op_e;

  typedef enum logic [2:0] {
    RES_NONE        = 3'd0,
    RES_HIT         = 3'd1,
    RES_FILL        = 3'd2,
    RES_EVICT       = 3'd3,
    RES_EVICT_DIRTY = 3'd4
  } ctc_res_e;
endpackage

// File: rtl/ctc_match.sv
module ctc_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 44,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [TAG_W-1:0]            req_tag,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [WAYS-1:0]             way_valid,
  output logic [WAYS-1:0]             hit_vec,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic                        has_free,
  output logic [WAY_W-1:0]            free_way
);
  // one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
  end

  assign hit      = |hit_vec;
  assign has_free = ~&way_valid;

  // tags in a set are unique, so at most one way matches
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = hit_way | WAY_W'(w);
  end

  // scan downward so the lowest invalid way wins
  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!way_valid[w]) free_way = WAY_W'(w);
  end
endmodule

// File: rtl/ctc_store.sv
module ctc_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 44,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0]             rd_dirty,
  input  logic                        inst_en,
  input  logic [WAY_W-1:0]            inst_way,
  input  logic [TAG_W-1:0]            inst_tag,
  input  logic                        inst_dirty,
  input  logic                        mark_en,
  input  logic [WAY_W-1:0]            mark_way,
  input  logic [WAYS-1:0]             clean_mask,
  input  logic [WAYS-1:0]             drop_mask,
  input  logic                        flush_all,
  input  logic                        drop_all
);
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            dirty_q [SETS];

  logic [WAYS-1:0] inst_1h, mark_1h;
  assign inst_1h = inst_en ? (WAYS'(1) << inst_way) : '0;
  assign mark_1h = mark_en ? (WAYS'(1) << mark_way) : '0;

  // tags carry no reset: valid gates every use
  always_ff @(posedge clk) begin
    if (inst_en) tag_q[rd_set][inst_way] <= inst_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (drop_all) begin
        for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end else begin
        valid_q[rd_set] <= (valid_q[rd_set] & ~drop_mask) | inst_1h;
      end
      if (flush_all) begin
        for (int s = 0; s < SETS; s++) dirty_q[s] <= '0;
      end else begin
        dirty_q[rd_set] <= (dirty_q[rd_set] & ~(clean_mask | drop_mask | inst_1h))
                         | (inst_dirty ? inst_1h : '0) | mark_1h;
      end
    end
  end

  assign rd_tag   = tag_q[rd_set];
  assign rd_valid = valid_q[rd_set];
  assign rd_dirty = dirty_q[rd_set];
endmodule

// File: rtl/ctc_plru.sv
module ctc_plru #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int NODES  = WAYS - 1,
  localparam int LEVELS = WAY_W,
  localparam int BOTTOM = (WAYS - 2) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic              upd_en,
  input  logic [SET_W-1:0]  upd_set,
  input  logic [WAY_W-1:0]  upd_way,
  input  logic [SET_W-1:0]  qry_set,
  output logic [WAY_W-1:0]  victim_way
);
  // node indices fit in WAY_W bits because NODES < WAYS
  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] t,
                                             input logic [WAY_W-1:0] w);
    logic [NODES-1:0] r;
    logic [WAY_W-1:0] idx;
    logic [WAY_W-1:0] par;
    r   = t;
    idx = (w >> 1) + WAY_W'(BOTTOM);
    r[idx] = ~w[0];
    for (int l = 1; l < LEVELS; l++) begin
      par    = (idx - WAY_W'(1)) >> 1;
      r[par] = idx[0];
      idx    = par;
    end
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] pick(input logic [NODES-1:0] t);
    logic [WAY_W-1:0] idx;
    idx = '0;
    for (int l = 0; l < LEVELS - 1; l++)
      idx = t[idx] ? ((idx << 1) + WAY_W'(2)) : ((idx << 1) + WAY_W'(1));
    return ((idx - WAY_W'(BOTTOM)) << 1) | WAY_W'(t[idx]);
  endfunction

  logic [SETS-1:0][NODES-1:0] tree_all;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [NODES-1:0] node_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 node_q <= '0;
      else if (clear_all)                         node_q <= '0;
      else if (upd_en && upd_set == SET_W'(s))    node_q <= touch(node_q, upd_way);
    end
    assign tree_all[s] = node_q;
  end

  assign victim_way = pick(tree_all[qry_set]);
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl #(
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 56,
  parameter int TAG_W  = 44,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int OFF_W = ADDR_W - TAG_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic [2:0]        res_code,
  output logic [WAY_W-1:0]  res_way
);
  import ctc_pkg::*;

  logic                       ready_q;
  ctc_op_e                    op;
  logic                       take;
  logic [TAG_W-1:0]           a_tag;
  logic [SET_W-1:0]           a_set;
  logic [WAYS-1:0][TAG_W-1:0] s_tag;
  logic [WAYS-1:0]            s_valid, s_dirty, hit_vec;
  logic                       hit, has_free;
  logic [WAY_W-1:0]           hit_way, free_way, victim_way, use_way;
  logic                       do_lookup;
  ctc_res_e                   res_next, res_q;
  logic [WAY_W-1:0]           way_q;

  assign op    = ctc_op_e'(req_op);
  assign take  = req_valid && ready_q;
  assign a_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign a_set = req_addr[OFF_W +: SET_W];
  assign do_lookup = take && (op == OP_LOOKUP);

  ctc_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_set     (a_set),
    .rd_tag     (s_tag),
    .rd_valid   (s_valid),
    .rd_dirty   (s_dirty),
    .inst_en    (do_lookup && !hit),
    .inst_way   (use_way),
    .inst_tag   (a_tag),
    .inst_dirty (req_write),
    .mark_en    (do_lookup && hit && req_write),
    .mark_way   (hit_way),
    .clean_mask ((take && op == OP_CLEAN_LINE) ? hit_vec : '0),
    .drop_mask  ((take && op == OP_DROP_LINE)  ? hit_vec : '0),
    .flush_all  (take && op == OP_FLUSH_ALL),
    .drop_all   (take && (op == OP_DROP_ALL || op == OP_RESTART))
  );

  ctc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .req_tag   (a_tag),
    .way_tag   (s_tag),
    .way_valid (s_valid),
    .hit_vec   (hit_vec),
    .hit       (hit),
    .hit_way   (hit_way),
    .has_free  (has_free),
    .free_way  (free_way)
  );

  ctc_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_all  (take && op == OP_RESTART),
    .upd_en     (do_lookup),
    .upd_set    (a_set),
    .upd_way    (use_way),
    .qry_set    (a_set),
    .victim_way (victim_way)
  );

  always_comb begin
    if (hit) begin
      use_way  = hit_way;
      res_next = RES_HIT;
    end else if (has_free) begin
      use_way  = free_way;
      res_next = RES_FILL;
    end else begin
      use_way  = victim_way;
      res_next = s_dirty[victim_way] ? RES_EVICT_DIRTY : RES_EVICT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      res_q   <= RES_NONE;
      way_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      res_q   <= do_lookup ? res_next : RES_NONE;
      way_q   <= do_lookup ? use_way : '0;
    end
  end

  assign req_ready = ready_q;
  assign res_code  = res_q;
  assign res_way   = way_q;
endmodule

// File: rtl/ctc_checker.sv
module ctc_checker #(
  parameter int ADDR_W = 56,
  parameter int WAYS   = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [2:0]        res_code,
  input logic [WAY_W-1:0]  res_way
);
  logic acc, acc_lookup, acc_clear;
  assign acc        = req_valid && req_ready;
  assign acc_lookup = acc && (req_op == 3'd0);
  assign acc_clear  = acc && (req_op == 3'd2 || req_op == 3'd5);

  a_r10_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> req_ready);

  a_r9_none_when_no_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_lookup) |-> res_code == 3'd0);

  a_r9_result_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_lookup) |-> (res_code >= 3'd1 && res_code <= 3'd4));

  a_r2_repeat_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_lookup && $past(acc_lookup) && req_addr == $past(req_addr))
      |=> (res_code == 3'd1 && res_way == $past(res_way)));

  a_r7_fill_way0_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_clear) && acc_lookup) |=> (res_code == 3'd2 && res_way == '0));
endmodule

bind cache_tag_ctrl ctc_checker #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .res_code  (res_code),
  .res_way   (res_way)
);

// File: tb/sim_cache_tag_ctrl.sv
module sim_cache_tag_ctrl;
  localparam int SETS = 4, WAYS = 4, ADDR_W = 12, TAG_W = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [2:0]        req_op = 3'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic [2:0]        res_code;
  logic [1:0]        res_way;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  cache_tag_ctrl #(.SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u0 (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_addr, .req_write,
    .res_code, .res_way
  );

  // reference state
  logic [5:0] m_tag [4][4];
  logic       m_v   [4][4];
  logic       m_d   [4][4];
  logic [2:0] m_t   [4];   // {node2, node1, node0}

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(int tg, int st, int off);
    return {6'(tg), 2'(st), 4'(off)};
  endfunction

  function automatic int m_victim(int s);
    if (m_t[s][0] == 1'b0) return m_t[s][1] ? 1 : 0;
    return m_t[s][2] ? 3 : 2;
  endfunction

  task automatic m_touch(int s, int w);
    if (w < 2) begin m_t[s][0] = 1'b1; m_t[s][1] = (w == 0); end
    else       begin m_t[s][0] = 1'b0; m_t[s][2] = (w == 2); end
  endtask

  task automatic m_reset();
    for (int s = 0; s < 4; s++) begin
      m_t[s] = 3'b000;
      for (int w = 0; w < 4; w++) begin m_v[s][w] = 0; m_d[s][w] = 0; m_tag[s][w] = 0; end
    end
  endtask

  task automatic lookup(logic [11:0] a, bit wr, string tagname);
    int s, tg, hw, fw, ec, ew;
    string rq, rw;
    tg = int'(a[11:6]); s = int'(a[5:4]);
    hw = -1; fw = -1;
    for (int w = 0; w < 4; w++) if (m_v[s][w] && m_tag[s][w] == 6'(tg)) hw = w;
    for (int w = 3; w >= 0; w--) if (!m_v[s][w]) fw = w;
    if (hw >= 0) begin
      ec = 1; ew = hw; rq = "R2";
      if (wr) m_d[s][hw] = 1;
    end else if (fw >= 0) begin
      ec = 2; ew = fw; rq = "R3";
      m_v[s][fw] = 1; m_d[s][fw] = wr; m_tag[s][fw] = 6'(tg);
    end else begin
      ew = m_victim(s); ec = m_d[s][ew] ? 4 : 3; rq = "R4";
      m_d[s][ew] = wr; m_tag[s][ew] = 6'(tg);
    end
    m_touch(s, ew);
    rw = (ec >= 3) ? "R5" : rq;
    if (tagname != "") begin rq = tagname; rw = tagname; end
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd0; req_addr = a; req_write = wr;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(rq, int'(res_code), ec);
    chk(rw, int'(res_way), ew);
  endtask

  task automatic command(int op, logic [11:0] a);
    int s, tg;
    string rq;
    tg = int'(a[11:6]); s = int'(a[5:4]);
    case (op)
      1: begin rq = "R6"; for (int i = 0; i < 4; i++) for (int w = 0; w < 4; w++) m_d[i][w] = 0; end
      2, 5: begin
        rq = "R7";
        for (int i = 0; i < 4; i++) begin
          for (int w = 0; w < 4; w++) m_v[i][w] = 0;
          if (op == 5) m_t[i] = 3'b000;
        end
      end
      3, 4: begin
        rq = "R8";
        for (int w = 0; w < 4; w++)
          if (m_v[s][w] && m_tag[s][w] == 6'(tg)) begin
            m_d[s][w] = 0;
            if (op == 4) m_v[s][w] = 0;
          end
      end
      default: rq = "R9";
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_addr = a; req_write = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk(rq, int'(res_code), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int r, op;
    m_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R10", int'(req_ready), 0);
    chk("R9", int'(res_code), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10", int'(req_ready), 1);

    // R1: offset ignored, set index separates lines
    lookup(mk(3, 1, 0), 1'b0, "R1");
    lookup(mk(3, 1, 15), 1'b0, "R1");
    lookup(mk(3, 2, 7), 1'b0, "R1");
    @(posedge clk); #1;
    chk("R9", int'(res_code), 0);

    // fill a set, write-hit, then evict dirty and clean lines
    command(5, '0);
    for (int t = 10; t < 14; t++) lookup(mk(t, 0, 0), 1'b0, "");
    lookup(mk(11, 0, 3), 1'b1, "R2");
    for (int t = 20; t < 26; t++) lookup(mk(t, 0, 0), 1'b0, "");
    command(1, '0);
    lookup(mk(30, 0, 0), 1'b0, "R6");
    command(6, mk(30, 0, 0));
    command(7, mk(30, 0, 0));
    lookup(mk(30, 0, 0), 1'b0, "R9");
    command(4, mk(30, 0, 0));
    lookup(mk(31, 0, 0), 1'b1, "R8");
    command(2, '0);
    lookup(mk(32, 0, 0), 1'b0, "R7");

    // pseudo-random sweep over a small tag space
    seed = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      r = int'(seed >> 1);
      op = (r >> 3) % 40;
      if (op < 30)       lookup(mk((r >> 9) % 6, (r >> 13) % 4, (r >> 16) % 16), r[20], "");
      else if (op < 32)  command(1, '0);
      else if (op == 32) command(2, '0);
      else if (op < 35)  command(3, mk((r >> 9) % 6, (r >> 13) % 4, 0));
      else if (op < 37)  command(4, mk((r >> 9) % 6, (r >> 13) % 4, 0));
      else if (op == 37) command(((r >> 22) % 8 == 0) ? 5 : 6, '0);
      else if (op == 38) command(7, mk((r >> 9) % 6, (r >> 13) % 4, 0));
      else begin @(posedge clk); #1; chk("R9", int'(res_code), 0); end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule